// File: doc/BRIEF.md
# Time-Multiplexed Lookup-Table Cell

This block is one reconfigurable logic cell. It is built around a 4-input lookup table whose 16 entries each hold a small word, with one bit for each of eight contexts, rather than a single bit. A free-running fold counter visits the contexts in a fixed order, one per fast clock cycle. In each cycle the cell looks up the bit that belongs to the current context, at the entry addressed by the four inputs, and registers it. One cell can therefore implement eight different logic functions inside each apparent user cycle. One user cycle is a complete pass through all eight contexts, so the fast clock runs eight times faster than the clock the user logic sees.

The inputs may take a different value in every fast cycle, so each context works on its own operands. The truth tables are loaded through a slow configuration port that writes one bit at a time. That port only acts while a configuration-mode input is high, and the fold counter is held at context 0 for as long as that mode lasts. A strobe marks the last context of each user cycle, so that neighbouring logic can line itself up with user-cycle boundaries.

Top module: `tmlut_cell`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `ctx_idx` is 0, `lut_out` is 0 and `user_strobe` is 0. Reset is synchronous and active-high.
- R2: While `cfg_mode` is low, `ctx_idx` steps by one on every rising clock edge in the order 0,1,...,7 and then wraps from 7 back to 0.
- R3: On every rising edge at which `cfg_mode` is high, `ctx_idx` becomes 0, and it stays at 0 while `cfg_mode` remains high.
- R4: `user_strobe` is high exactly in those cycles where `ctx_idx` is 7, which is one fast cycle out of every eight during normal stepping.
- R5: If in some cycle `ctx_idx` equals k and `lut_in` equals a, then after the next rising edge `lut_out` equals the stored bit for entry a and context k.
- R6: A rising edge with `cfg_mode`=1 and `cfg_we`=1 stores `cfg_bit` as the bit for entry `cfg_addr`, context `cfg_ctx`. No other bit of the table changes.
- R7: A write request (`cfg_we`=1) made while `cfg_mode` is low does not change the table.
- R8: After reset every table bit is 0, so `lut_out` stays 0 for every input value and context until a bit is configured.
- R9: Contexts are independent of one another. Changing `lut_in` on every fast cycle yields, in each cycle, the result of the current context's own function applied to that cycle's input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 1 | Configuration mode; holds the fold counter at 0 and enables writes |
| cfg_we | input | 1 | Write request for one table bit |
| cfg_addr | input | 4 | Table entry to write |
| cfg_ctx | input | 3 | Context whose bit is written |
| cfg_bit | input | 1 | Value to store |
| lut_in | input | 4 | Lookup address, may change every fast cycle |
| lut_out | output | 1 | Registered lookup result |
| ctx_idx | output | 3 | Current context (fold counter) |
| user_strobe | output | 1 | High during the last context of a user cycle |

## Verification
The hardest case to reach from the ports is entering configuration mode while the counter sits in the middle of a pass, and then resuming. The output of the cycle in which the mode rises still belongs to the interrupted context, and stepping has to restart from context 0. The bench enters configuration mode after a randomly chosen number of normal cycles and checks every output against a model counter that it keeps itself. A write attempted outside configuration mode is caught by reading the targeted entry and context back through the normal lookup path later on.

// File: rtl/tmlut_pkg.sv
package tmlut_pkg;
  parameter int unsigned TM_IN_W  = 4;
  parameter int unsigned TM_CTX_N = 8;
  localparam int unsigned TM_CTX_W = $clog2(TM_CTX_N);

  typedef struct packed {
    logic                en;
    logic [TM_IN_W-1:0]  addr;
    logic [TM_CTX_W-1:0] ctx;
    logic                value;
  } tm_wr_t;
endpackage

// File: rtl/fold_sequencer.sv
module fold_sequencer #(
  parameter int unsigned CTX_N = 8,
  localparam int unsigned CTX_W = $clog2(CTX_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  output logic [CTX_W-1:0] ctx,
  output logic             last
);
  localparam logic [CTX_W-1:0] LAST_CTX = CTX_W'(CTX_N - 1);

  always_ff @(posedge clk) begin
    if (rst || hold)
      ctx <= '0;
    else if (ctx == LAST_CTX)
      ctx <= '0;
    else
      ctx <= ctx + 1'b1;
  end

  assign last = (ctx == LAST_CTX);
endmodule

// File: rtl/context_table.sv
module context_table
  import tmlut_pkg::*;
#(
  parameter int unsigned IN_W  = TM_IN_W,
  parameter int unsigned CTX_N = TM_CTX_N,
  localparam int unsigned CTX_W   = $clog2(CTX_N),
  localparam int unsigned ENTRIES = 1 << IN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  tm_wr_t           wr,
  input  logic [IN_W-1:0]  rd_addr,
  input  logic [CTX_W-1:0] rd_ctx,
  output logic             rd_q
);
  logic [CTX_N-1:0] rows [ENTRIES];

  // One register row per entry; each row holds a bit per context.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst)
        rows[e] <= '0;
      else if (wr.en && (wr.addr == IN_W'(e)))
        rows[e][wr.ctx] <= wr.value;
    end
  end

  // Registered read: the bit chosen now is visible after the next edge.
  always_ff @(posedge clk) begin
    if (rst)
      rd_q <= 1'b0;
    else
      rd_q <= rows[rd_addr][rd_ctx];
  end
endmodule

// File: rtl/tmlut_cell.sv
module tmlut_cell
  import tmlut_pkg::*;
#(
  parameter int unsigned IN_W  = TM_IN_W,
  parameter int unsigned CTX_N = TM_CTX_N,
  localparam int unsigned CTX_W = $clog2(CTX_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_mode,
  input  logic             cfg_we,
  input  logic [IN_W-1:0]  cfg_addr,
  input  logic [CTX_W-1:0] cfg_ctx,
  input  logic             cfg_bit,
  input  logic [IN_W-1:0]  lut_in,
  output logic             lut_out,
  output logic [CTX_W-1:0] ctx_idx,
  output logic             user_strobe
);
  tm_wr_t wr_req;

  assign wr_req.en    = cfg_mode & cfg_we;
  assign wr_req.addr  = cfg_addr;
  assign wr_req.ctx   = cfg_ctx;
  assign wr_req.value = cfg_bit;

  fold_sequencer #(.CTX_N(CTX_N)) u_seq (
    .clk  (clk),
    .rst  (rst),
    .hold (cfg_mode),
    .ctx  (ctx_idx),
    .last (user_strobe)
  );

  context_table #(.IN_W(IN_W), .CTX_N(CTX_N)) u_tab (
    .clk     (clk),
    .rst     (rst),
    .wr      (wr_req),
    .rd_addr (lut_in),
    .rd_ctx  (ctx_idx),
    .rd_q    (lut_out)
  );
endmodule

// File: rtl/tmlut_cell_chk.sv
module tmlut_cell_chk #(
  parameter int unsigned CTX_N = 8,
  localparam int unsigned CTX_W = $clog2(CTX_N)
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_mode,
  input logic [CTX_W-1:0] ctx_idx,
  input logic             user_strobe,
  input logic             lut_out
);
  localparam logic [CTX_W-1:0] LAST_CTX = CTX_W'(CTX_N - 1);

  // R1: reset clears counter and output
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (ctx_idx == '0 && !lut_out && !user_strobe));

  // R2: normal stepping advances by one and wraps
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    !cfg_mode |=> ctx_idx == (($past(ctx_idx) == LAST_CTX) ? '0 : $past(ctx_idx) + 1'b1));

  // R3: configuration mode pins the counter at 0
  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_mode |=> ctx_idx == '0);

  // R4: strobe marks the end of a pass, after which context 0 follows
  p_strobe_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    user_strobe |=> (ctx_idx == '0 && !user_strobe));
endmodule

bind tmlut_cell tmlut_cell_chk #(.CTX_N(CTX_N)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_mode    (cfg_mode),
  .ctx_idx     (ctx_idx),
  .user_strobe (user_strobe),
  .lut_out     (lut_out)
);

// File: tb/test_tmlut_cell.sv
`timescale 1ns/1ps
module test_tmlut_cell;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_mode = 1'b0, cfg_we = 1'b0, cfg_bit = 1'b0;
  logic [3:0] cfg_addr = '0, lut_in = '0;
  logic [2:0] cfg_ctx = '0;
  logic       lut_out, user_strobe;
  logic [2:0] ctx_idx;

  int checks = 0, failures = 0;
  logic [7:0] ref_tab [16];
  int m_ctx = 0;

  always #4 clk = ~clk;

  tmlut_cell i_tmlut_cell (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_ctx(cfg_ctx), .cfg_bit(cfg_bit),
    .lut_in(lut_in), .lut_out(lut_out), .ctx_idx(ctx_idx),
    .user_strobe(user_strobe)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int next_ctx(input int c, input logic cm);
    return cm ? 0 : (c + 1) % 8;
  endfunction

  // One fast cycle: called just after a falling edge.
  task automatic cyc(input logic cm, input logic we, input logic [3:0] a,
                     input logic [2:0] c, input logic b, input logic [3:0] din);
    int exp_out;
    check("R2 ctx", ctx_idx, m_ctx);
    check("R4 strobe", user_strobe, (m_ctx == 7) ? 1 : 0);
    cfg_mode = cm; cfg_we = we; cfg_addr = a; cfg_ctx = c; cfg_bit = b; lut_in = din;
    exp_out = ref_tab[din][m_ctx];
    if (cm && we) ref_tab[a][c] = b;          // R6; a write with cm low is ignored (R7)
    m_ctx = next_ctx(m_ctx, cm);
    @(negedge clk);
    check("R5 R9 lut_out", lut_out, exp_out);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 16; i++) ref_tab[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 ctx in reset", ctx_idx, 0);
    check("R1 out in reset", lut_out, 0);
    check("R1 strobe in reset", user_strobe, 0);
    rst = 1'b0;
    m_ctx = 0;

    // R8: empty table reads 0 for every input over two passes
    for (int i = 0; i < 16; i++) cyc(0, 0, 0, 0, 0, 4'(i));

    // Directed: set entry 5 ctx 3, then try to clear it outside cfg mode (R7)
    cyc(1, 1, 4'd5, 3'd3, 1'b1, 4'd0);
    cyc(0, 0, 0, 0, 0, 4'd0);
    for (int i = 0; i < 10; i++) cyc(0, 1, 4'd5, 3'd3, 1'b0, 4'd5);
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 0, 4'd5);
    check("R7 entry5 ctx3 kept", ref_tab[5][3], 1);

    // Random full table load, entered mid-pass (R3, R6)
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 4'($urandom));
    for (int e = 0; e < 16; e++)
      for (int c = 0; c < 8; c++)
        cyc(1, 1, 4'(e), 3'(c), 1'($urandom), 4'($urandom));

    // Random inputs every fast cycle, with occasional partial reconfiguration
    for (int r = 0; r < 6; r++) begin
      int n = 40 + ($urandom % 60);
      for (int i = 0; i < n; i++) cyc(0, 1'($urandom), 4'($urandom), 3'($urandom), 1'($urandom), 4'($urandom));
      for (int i = 0; i < 5; i++) cyc(1, 1'($urandom), 4'($urandom), 3'($urandom), 1'($urandom), 4'($urandom));
    end

    // Alternating patterns per context: context k sees input k (R9)
    for (int i = 0; i < 32; i++) cyc(0, 0, 0, 0, 0, 4'(m_ctx));

    // Reset in mid-run clears everything (R1, R8)
    cfg_mode = 0; cfg_we = 0;
    rst = 1'b1;
    @(negedge clk);
    check("R1 ctx after reset", ctx_idx, 0);
    check("R1 out after reset", lut_out, 0);
    rst = 1'b0;
    m_ctx = 0;
    for (int i = 0; i < 16; i++) ref_tab[i] = '0;
    for (int i = 0; i < 24; i++) cyc(0, 0, 0, 0, 0, 4'($urandom));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule